// File: doc/BRIEF.md
# Periodic Calibration List Sequencer

This block steps through a short circular list of periodic receive-path calibrations. Each entry has a kind (IQ mismatch, temperature compensation, or one of two ADC kinds that are not supported) and a state that is waiting, running or done. The block advances only on a periodic tick. On a tick it looks at the entry under its pointer. A waiting entry whose bit in the per-channel valid mask is clear is reset and started. A running entry whose measurement engine has gone idle has its result collected, and the shared sub-sample counter is incremented. When that counter reaches the entry's required count, the block asks for post-processing and passes the number of active receive chains. It then sets the entry's valid bit, marks the entry done and moves the pointer on.

The caller sees one completion flag per tick. The flag stays low while any further entry still waits, because such an entry is started in the same step. Clearing valid bits puts those entries back into the waiting state, so they run again. A tick flagged as long-interval also fires a fixed three-step noise-floor sequence, independent of the list. Measurement engines, accumulators and arithmetic are outside this block: it only drives their start, collect and post-process strobes.

Top module: `cal_seq`

## Requirements
- R1: After reset, the valid mask is all zero, cal_done and done_vld are 0, and no strobe is active. Every supported entry is waiting and the pointer is at the lowest supported entry.
- R2: If the current entry is waiting with its valid bit clear, a tick resets it:
    - acc_clear is raised with acc_idx set to that entry;
    - the sub-sample counter is set to zero;
    - the entry becomes running and is started;
    - cal_done is 0.
- R3: A tick that finds the current entry running with its meas_busy bit high produces no collect, no post_proc and no start, and reports cal_done 0.
- R4: A tick that finds the current entry running with meas_busy low raises collect (ent_idx = entry) and increments the shared counter. If the new count is below the entry's required count, the entry is started again and cal_done is 0.
- R5: When the incremented count reaches the required count:
    - post_proc is raised in the same cycle as collect;
    - the entry's chan_valid bit is set;
    - the entry becomes done;
    - the completion is reported as cal_done 1, unless R7 overrides it.
- R6: post_chains equals the number of set bits in the 3-bit rx_chain_mask sampled with the tick; a mask of 0 gives 0.
- R7: After a completion, the pointer moves circularly to the next supported entry. If that entry is waiting, it is reset and started on the same tick, in the R2 manner but regardless of its valid bit, and cal_done is forced to 0.
- R8: Starting an IQ entry (kind code 0) raises iq_cfg_wr with iq_log_count set to that entry's log count, so that 2^(count+1) samples are taken. It raises iq_do_cal one cycle later, with kick_idx = entry.
- R9: Starting a temperature entry (kind code 1) raises temp_local_set, then raises temp_start one cycle later, with kick_idx = entry.
- R10: A tick with tick_long high raises nf_read, nf_load and nf_start on three consecutive cycles, starting the cycle after the tick. A tick without tick_long raises none of them.
- R11: Entries of kind 2 or 3 are never started and never get a valid bit. The pointer never rests on them.
- R12: A tick that finds the current entry done reports cal_done 1 and raises no strobe.
- R13: A cycle with valid_clear nonzero:
    - clears those chan_valid bits;
    - puts the supported ones into waiting;
    - moves the pointer to the lowest cleared supported entry;
    - drops any list step for a tick in the same cycle (no done_vld).
- R14: done_vld is high exactly in the cycle after each tick that is not dropped. cal_done is updated in that cycle and holds until the next such tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Periodic calibration step request |
| tick_long | input | 1 | Marks a tick as long-interval (noise-floor step) |
| rx_chain_mask | input | 3 | Active receive chains |
| valid_clear | input | NUM_ENT | Clears per-channel valid bits, forcing recalibration |
| meas_busy | input | NUM_ENT | Measurement engine of each entry still running |
| chan_valid | output | NUM_ENT | Per-channel valid mask |
| cal_done | output | 1 | Completion flag reported for the last tick |
| done_vld | output | 1 | cal_done was updated this cycle |
| acc_clear | output | 1 | Clear accumulators of entry acc_idx |
| acc_idx | output | IDX_W | Entry whose accumulators are cleared |
| collect | output | 1 | Collect one sub-measurement of entry ent_idx |
| post_proc | output | 1 | Post-process accumulated results of entry ent_idx |
| ent_idx | output | IDX_W | Entry for collect and post_proc |
| post_chains | output | CH_W | Active chain count for post-processing |
| iq_cfg_wr | output | 1 | Program IQ sample log count and IQ mode |
| iq_log_count | output | LOG_W | Log count for the IQ measurement |
| iq_do_cal | output | 1 | Kick the IQ measurement |
| temp_local_set | output | 1 | Select local temperature sensing |
| temp_start | output | 1 | Kick the temperature measurement |
| kick_idx | output | IDX_W | Entry being kicked |
| nf_read | output | 1 | Read previous noise-floor result into history |
| nf_load | output | 1 | Load history value into the receiver |
| nf_start | output | 1 | Restart noise-floor measurement (baseband value untouched) |

## Verification
The list is driven through fixed-seed random sequences of ticks. In these sequences the busy lines are released at random points, the chain mask is random, long-interval flags are random, and valid bits are occasionally cleared. This separates a stalled measurement (busy still high) from a completed sub-sample and from a final sample that finishes an entry. Directed steps cover the corners:
- the two-sample IQ entry handing over to the temperature entry with a chain mask of zero;
- a completion that skips the unsupported entry and wraps to a done entry, which tells the masked completion apart from the true one;
- a valid clear that coincides with a long tick, which shows the clear taking priority over the list step while the noise-floor sequence still runs.

// File: rtl/cal_seq_pkg.sv
// Shared encodings for the calibration list sequencer.
package cal_seq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Life cycle of one list entry.
    typedef enum logic [1:0] {
        ENT_WAIT = 2'd0,
        ENT_RUN  = 2'd1,
        ENT_DONE = 2'd2
    } ent_state_e;

    // Calibration kind codes, two bits per entry.
    localparam logic [1:0] KIND_IQ       = 2'd0;
    localparam logic [1:0] KIND_TEMP     = 2'd1;
    localparam logic [1:0] KIND_ADC_GAIN = 2'd2;
    localparam logic [1:0] KIND_ADC_DC   = 2'd3;

    // Only IQ mismatch and temperature kinds can be run.
    function automatic logic kind_ok(input logic [1:0] kind);
        return (kind == KIND_IQ) || (kind == KIND_TEMP);
    endfunction
endpackage

// File: rtl/cal_seq_chain_cnt.sv
// Counts the active receive chains in a chain mask.
// Assumes: the mask is stable for the cycle in which it is used.
module cal_seq_chain_cnt #(
    parameter int NUM_CHAINS = 3,
    parameter int CH_W       = $clog2(NUM_CHAINS + 1)
) (
    input  logic [NUM_CHAINS-1:0] mask,
    output logic [CH_W-1:0]       count
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CH_W-1:0] part [NUM_CHAINS+1];

    assign part[0] = '0;

    // Ripple adder chain: one stage per chain bit.
    for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_add
        assign part[g+1] = part[g] + {{(CH_W-1){1'b0}}, mask[g]};
    end

    assign count = part[NUM_CHAINS];
endmodule

// File: rtl/cal_seq_nf.sv
// Noise-floor step sequencer: a long-interval tick produces read, load and
// restart strobes on three consecutive cycles.
// Assumes: overlapping requests are simply pipelined, each gets its sequence.
module cal_seq_nf #(
    parameter int NF_STEPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tick_long,
    output logic nf_read,
    output logic nf_load,
    output logic nf_start
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [NF_STEPS-1:0] step_q;

    // Shift the request through the fixed step order.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= {step_q[NF_STEPS-2:0], tick & tick_long};
    end

    assign nf_read  = step_q[0];
    assign nf_load  = step_q[1];
    assign nf_start = step_q[2];
endmodule

// File: rtl/cal_seq_kick.sv
// Start pipeline for measurement engines. A start request is first turned
// into a configuration strobe of the entry's kind, then one cycle later
// into the kick strobe of that kind.
// Assumes: start_idx names an existing entry whenever start_req is high.
module cal_seq_kick
    import cal_seq_pkg::*;
#(
    parameter int                      NUM_ENT  = 3,
    parameter int                      IDX_W    = 2,
    parameter int                      LOG_W    = 4,
    parameter logic [2*NUM_ENT-1:0]    ENT_KIND = '0,
    parameter logic [LOG_W*NUM_ENT-1:0] ENT_LOG = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [IDX_W-1:0] start_idx,
    output logic             iq_cfg_wr,
    output logic [LOG_W-1:0] iq_log_count,
    output logic             temp_local_set,
    output logic             iq_do_cal,
    output logic             temp_start,
    output logic [IDX_W-1:0] kick_idx
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [1:0]       kind_sel;
    logic             iq_go;
    logic             temp_go;
    logic [IDX_W-1:0] idx1_q;

    assign kind_sel = ENT_KIND[2*int'(start_idx) +: 2];
    assign iq_go    = start_req && (kind_sel == KIND_IQ);
    assign temp_go  = start_req && (kind_sel == KIND_TEMP);

    // Configuration phase: strobe kind-specific setup, hold the log count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iq_cfg_wr      <= 1'b0;
            temp_local_set <= 1'b0;
            iq_log_count   <= '0;
            idx1_q         <= '0;
        end else begin
            iq_cfg_wr      <= iq_go;
            temp_local_set <= temp_go;
            if (iq_go)
                iq_log_count <= ENT_LOG[LOG_W*int'(start_idx) +: LOG_W];
            if (iq_go || temp_go)
                idx1_q <= start_idx;
        end
    end

    // Kick phase: fire the engine one cycle after its configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iq_do_cal  <= 1'b0;
            temp_start <= 1'b0;
            kick_idx   <= '0;
        end else begin
            iq_do_cal  <= iq_cfg_wr;
            temp_start <= temp_local_set;
            kick_idx   <= idx1_q;
        end
    end
endmodule

// File: rtl/cal_seq.sv
// Calibration list sequencer. Steps a circular list of calibration entries
// on each tick: starts, collects sub-samples, requests post-processing and
// hands over to the next entry, masking completion while another waits.
// Assumes: each entry's required sample count is at least 1 and fits CNT_W;
// at least one entry is of a supported kind.
module cal_seq
    import cal_seq_pkg::*;
#(
    parameter int                        NUM_ENT    = 3,
    parameter int                        NUM_CHAINS = 3,
    parameter int                        CNT_W      = 4,
    parameter int                        LOG_W      = 4,
    parameter logic [2*NUM_ENT-1:0]      ENT_KIND   = {KIND_ADC_GAIN, KIND_TEMP, KIND_IQ},
    parameter logic [CNT_W*NUM_ENT-1:0]  ENT_NSAMP  = {4'd1, 4'd1, 4'd2},
    parameter logic [LOG_W*NUM_ENT-1:0]  ENT_LOG    = {4'd0, 4'd0, 4'd3},
    localparam int                       IDX_W      = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
    localparam int                       CH_W       = $clog2(NUM_CHAINS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  tick_long,
    input  logic [NUM_CHAINS-1:0] rx_chain_mask,
    input  logic [NUM_ENT-1:0]    valid_clear,
    input  logic [NUM_ENT-1:0]    meas_busy,
    output logic [NUM_ENT-1:0]    chan_valid,
    output logic                  cal_done,
    output logic                  done_vld,
    output logic                  acc_clear,
    output logic [IDX_W-1:0]      acc_idx,
    output logic                  collect,
    output logic                  post_proc,
    output logic [IDX_W-1:0]      ent_idx,
    output logic [CH_W-1:0]       post_chains,
    output logic                  iq_cfg_wr,
    output logic [LOG_W-1:0]      iq_log_count,
    output logic                  iq_do_cal,
    output logic                  temp_local_set,
    output logic                  temp_start,
    output logic [IDX_W-1:0]      kick_idx,
    output logic                  nf_read,
    output logic                  nf_load,
    output logic                  nf_start
);
    timeunit 1ns;
    timeprecision 1ps;

    // Mask of entries whose kind can be run.
    function automatic logic [NUM_ENT-1:0] sup_of(input logic [2*NUM_ENT-1:0] kinds);
        logic [NUM_ENT-1:0] r;
        for (int e = 0; e < NUM_ENT; e++) r[e] = kind_ok(kinds[2*e +: 2]);
        return r;
    endfunction

    // Index of the lowest set bit, zero for an empty mask.
    function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_ENT-1:0] m);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int e = NUM_ENT - 1; e >= 0; e--)
            if (m[e]) r = e[IDX_W-1:0];
        return r;
    endfunction

    localparam logic [NUM_ENT-1:0] SUP_MASK  = sup_of(ENT_KIND);
    localparam logic [IDX_W-1:0]   FIRST_SUP = lowest_set(SUP_MASK);

    // Next supported entry after cur, walking circularly.
    function automatic logic [IDX_W-1:0] next_sup(input logic [IDX_W-1:0] cur);
        logic [IDX_W-1:0] r;
        logic             found;
        int               j;
        r     = cur;
        found = 1'b0;
        for (int k = 1; k <= NUM_ENT; k++) begin
            j = (int'(cur) + k) % NUM_ENT;
            if (!found && SUP_MASK[j]) begin
                r     = j[IDX_W-1:0];
                found = 1'b1;
            end
        end
        return r;
    endfunction

    ent_state_e         st_q [NUM_ENT];
    ent_state_e         st_d [NUM_ENT];
    logic [NUM_ENT-1:0] valid_q, valid_d;
    logic [IDX_W-1:0]   ptr_q, ptr_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_inc;
    logic [CNT_W-1:0]   need_cur;
    logic [IDX_W-1:0]   nxt;
    logic [NUM_ENT-1:0] clr_eff;
    logic               fin;
    logic               done_d, dvld_d, coll_d, post_d, acc_d;
    logic [IDX_W-1:0]   ent_idx_d, acc_idx_d;
    logic [CH_W-1:0]    chains_d, chain_cnt;
    logic               start_req;
    logic [IDX_W-1:0]   start_idx;

    assign clr_eff  = valid_clear & SUP_MASK;
    assign need_cur = ENT_NSAMP[CNT_W*int'(ptr_q) +: CNT_W];
    assign cnt_inc  = cnt_q + 1'b1;
    assign nxt      = next_sup(ptr_q);

    cal_seq_chain_cnt #(
        .NUM_CHAINS (NUM_CHAINS),
        .CH_W       (CH_W)
    ) u_chain_cnt (
        .mask  (rx_chain_mask),
        .count (chain_cnt)
    );

    // List step: valid clears first, otherwise one tick of the current entry.
    always_comb begin
        st_d      = st_q;
        valid_d   = valid_q;
        ptr_d     = ptr_q;
        cnt_d     = cnt_q;
        done_d    = cal_done;
        dvld_d    = 1'b0;
        coll_d    = 1'b0;
        post_d    = 1'b0;
        acc_d     = 1'b0;
        ent_idx_d = ent_idx;
        acc_idx_d = acc_idx;
        chains_d  = post_chains;
        start_req = 1'b0;
        start_idx = ptr_q;
        fin       = 1'b0;
        if (|valid_clear) begin
            valid_d = valid_q & ~valid_clear;
            for (int e = 0; e < NUM_ENT; e++)
                if (clr_eff[e]) st_d[e] = ENT_WAIT;
            if (|clr_eff) ptr_d = lowest_set(clr_eff);
        end else if (tick) begin
            dvld_d = 1'b1;
            done_d = 1'b1;
            if (st_q[ptr_q] == ENT_RUN) begin
                done_d = 1'b0;
                if (!meas_busy[ptr_q]) begin
                    coll_d    = 1'b1;
                    ent_idx_d = ptr_q;
                    cnt_d     = cnt_inc;
                    if (cnt_inc >= need_cur) begin
                        post_d         = 1'b1;
                        chains_d       = chain_cnt;
                        valid_d[ptr_q] = 1'b1;
                        st_d[ptr_q]    = ENT_DONE;
                        done_d         = 1'b1;
                        fin            = 1'b1;
                    end else begin
                        start_req = 1'b1;
                        start_idx = ptr_q;
                    end
                end
            end else if (st_q[ptr_q] == ENT_WAIT) begin
                done_d = 1'b0;
                if (!valid_q[ptr_q]) begin
                    cnt_d       = '0;
                    acc_d       = 1'b1;
                    acc_idx_d   = ptr_q;
                    st_d[ptr_q] = ENT_RUN;
                    start_req   = 1'b1;
                    start_idx   = ptr_q;
                end
            end
            if (fin) begin
                ptr_d = nxt;
                if (st_d[nxt] == ENT_WAIT) begin
                    done_d    = 1'b0;
                    cnt_d     = '0;
                    acc_d     = 1'b1;
                    acc_idx_d = nxt;
                    st_d[nxt] = ENT_RUN;
                    start_req = 1'b1;
                    start_idx = nxt;
                end
            end
        end
    end

    // State and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_ENT; e++)
                st_q[e] <= SUP_MASK[e] ? ENT_WAIT : ENT_DONE;
            valid_q     <= '0;
            ptr_q       <= FIRST_SUP;
            cnt_q       <= '0;
            cal_done    <= 1'b0;
            done_vld    <= 1'b0;
            collect     <= 1'b0;
            post_proc   <= 1'b0;
            acc_clear   <= 1'b0;
            ent_idx     <= '0;
            acc_idx     <= '0;
            post_chains <= '0;
        end else begin
            st_q        <= st_d;
            valid_q     <= valid_d;
            ptr_q       <= ptr_d;
            cnt_q       <= cnt_d;
            cal_done    <= done_d;
            done_vld    <= dvld_d;
            collect     <= coll_d;
            post_proc   <= post_d;
            acc_clear   <= acc_d;
            ent_idx     <= ent_idx_d;
            acc_idx     <= acc_idx_d;
            post_chains <= chains_d;
        end
    end

    assign chan_valid = valid_q;

    cal_seq_kick #(
        .NUM_ENT  (NUM_ENT),
        .IDX_W    (IDX_W),
        .LOG_W    (LOG_W),
        .ENT_KIND (ENT_KIND),
        .ENT_LOG  (ENT_LOG)
    ) u_kick (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_req      (start_req),
        .start_idx      (start_idx),
        .iq_cfg_wr      (iq_cfg_wr),
        .iq_log_count   (iq_log_count),
        .temp_local_set (temp_local_set),
        .iq_do_cal      (iq_do_cal),
        .temp_start     (temp_start),
        .kick_idx       (kick_idx)
    );

    cal_seq_nf #(
        .NF_STEPS (3)
    ) u_nf (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tick_long (tick_long),
        .nf_read   (nf_read),
        .nf_load   (nf_load),
        .nf_start  (nf_start)
    );
endmodule

// File: rtl/cal_seq_chk.sv
// Port-level properties of the calibration list sequencer, bound to it.
// Assumes: the same parameters as the bound instance.
module cal_seq_chk
    import cal_seq_pkg::*;
#(
    parameter int                   NUM_ENT    = 3,
    parameter int                   NUM_CHAINS = 3,
    parameter int                   IDX_W      = 2,
    parameter int                   CH_W       = 2,
    parameter logic [2*NUM_ENT-1:0] ENT_KIND   = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  tick_long,
    input logic [NUM_CHAINS-1:0] rx_chain_mask,
    input logic [NUM_ENT-1:0]    valid_clear,
    input logic [NUM_ENT-1:0]    chan_valid,
    input logic                  cal_done,
    input logic                  done_vld,
    input logic                  acc_clear,
    input logic                  collect,
    input logic                  post_proc,
    input logic [IDX_W-1:0]      ent_idx,
    input logic [CH_W-1:0]       post_chains,
    input logic                  iq_cfg_wr,
    input logic                  iq_do_cal,
    input logic                  temp_local_set,
    input logic                  temp_start,
    input logic [IDX_W-1:0]      kick_idx,
    input logic                  nf_read,
    input logic                  nf_load,
    input logic                  nf_start
);
    timeunit 1ns;
    timeprecision 1ps;

    logic kick_kind_ok;
    assign kick_kind_ok = kind_ok(ENT_KIND[2*int'(kick_idx) +: 2]);

    // R8
    iq_kick_follows_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iq_cfg_wr |=> iq_do_cal);

    // R9
    temp_kick_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temp_local_set |=> temp_start);

    // R10
    nf_read_after_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && tick_long) |=> nf_read);

    // R10
    nf_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nf_read |=> (nf_load ##1 nf_start));

    // R14
    done_vld_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (valid_clear == '0)) |=> done_vld);

    // R14
    done_vld_has_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld |-> $past(tick));

    // R5
    post_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_proc |-> (collect && chan_valid[ent_idx]));

    // R6
    post_chain_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_proc |-> (int'(post_chains) == $countones($past(rx_chain_mask))));

    // R7
    post_done_or_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_proc |-> (cal_done || acc_clear));

    // R11
    kick_supported_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iq_do_cal || temp_start) |-> kick_kind_ok);

    // R3
    collect_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collect |-> done_vld);

    // R13
    clear_drops_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_clear != '0) |=> (!done_vld && ((chan_valid & $past(valid_clear)) == '0)));
endmodule

bind cal_seq cal_seq_chk #(
    .NUM_ENT    (NUM_ENT),
    .NUM_CHAINS (NUM_CHAINS),
    .IDX_W      (IDX_W),
    .CH_W       (CH_W),
    .ENT_KIND   (ENT_KIND)
) u_cal_seq_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .tick_long      (tick_long),
    .rx_chain_mask  (rx_chain_mask),
    .valid_clear    (valid_clear),
    .chan_valid     (chan_valid),
    .cal_done       (cal_done),
    .done_vld       (done_vld),
    .acc_clear      (acc_clear),
    .collect        (collect),
    .post_proc      (post_proc),
    .ent_idx        (ent_idx),
    .post_chains    (post_chains),
    .iq_cfg_wr      (iq_cfg_wr),
    .iq_do_cal      (iq_do_cal),
    .temp_local_set (temp_local_set),
    .temp_start     (temp_start),
    .kick_idx       (kick_idx),
    .nf_read        (nf_read),
    .nf_load        (nf_load),
    .nf_start       (nf_start)
);

// File: tb/cal_seq_bench.sv
// Self-checking bench for cal_seq with its default three-entry list:
// entry 0 IQ (2 samples, log count 3), entry 1 temperature (1 sample),
// entry 2 ADC gain (unsupported).
module cal_seq_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N = 3;
    localparam int ST_WAIT = 0, ST_RUN = 1, ST_DONE = 2;
    localparam int B_KIND [N] = '{0, 1, 2};
    localparam int B_NEED [N] = '{2, 1, 1};
    localparam int B_LOG  [N] = '{3, 0, 0};
    localparam bit B_SUP  [N] = '{1'b1, 1'b1, 1'b0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       tick_long = 1'b0;
    logic [2:0] rx_chain_mask = 3'b000;
    logic [2:0] valid_clear = 3'b000;
    logic [2:0] meas_busy = 3'b000;
    logic [2:0] chan_valid;
    logic       cal_done, done_vld, acc_clear, collect, post_proc;
    logic [1:0] acc_idx, ent_idx, post_chains, kick_idx;
    logic       iq_cfg_wr, iq_do_cal, temp_local_set, temp_start;
    logic [3:0] iq_log_count;
    logic       nf_read, nf_load, nf_start;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state of the list.
    int       m_st [N];
    bit [2:0] m_valid;
    int       m_ptr;
    int       m_cnt;
    bit       m_done;

    cal_seq u_cal_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tick_long(tick_long),
        .rx_chain_mask(rx_chain_mask), .valid_clear(valid_clear), .meas_busy(meas_busy),
        .chan_valid(chan_valid), .cal_done(cal_done), .done_vld(done_vld),
        .acc_clear(acc_clear), .acc_idx(acc_idx), .collect(collect), .post_proc(post_proc),
        .ent_idx(ent_idx), .post_chains(post_chains), .iq_cfg_wr(iq_cfg_wr),
        .iq_log_count(iq_log_count), .iq_do_cal(iq_do_cal), .temp_local_set(temp_local_set),
        .temp_start(temp_start), .kick_idx(kick_idx), .nf_read(nf_read), .nf_load(nf_load),
        .nf_start(nf_start)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int popcnt3(input bit [2:0] m);
        return int'(m[0]) + int'(m[1]) + int'(m[2]);
    endfunction

    function automatic int next_entry(input int cur);
        for (int k = 1; k <= N; k++)
            if (B_SUP[(cur + k) % N]) return (cur + k) % N;
        return cur;
    endfunction

    task automatic model_reset();
        for (int e = 0; e < N; e++) m_st[e] = B_SUP[e] ? ST_WAIT : ST_DONE;
        m_valid = 3'b000;
        m_ptr = 0;
        m_cnt = 0;
        m_done = 1'b0;
    endtask

    // One list tick: drive, predict, then check strobes over the next cycles.
    task automatic do_tick(input bit lng);
        bit e_coll, e_post, e_acc, fin;
        int e_chains, e_acc_idx, e_start, c;
        @(negedge clk);
        tick = 1'b1;
        tick_long = lng;
        e_coll = 0; e_post = 0; e_acc = 0; fin = 0;
        e_chains = 0; e_acc_idx = 0; e_start = -1;
        c = m_ptr;
        m_done = 1'b1;
        if (m_st[c] == ST_RUN) begin
            m_done = 1'b0;
            if (!meas_busy[c]) begin
                e_coll = 1;
                m_cnt++;
                if (m_cnt >= B_NEED[c]) begin
                    e_post = 1;
                    e_chains = popcnt3(rx_chain_mask);
                    m_valid[c] = 1'b1;
                    m_st[c] = ST_DONE;
                    m_done = 1'b1;
                    fin = 1;
                end else begin
                    e_start = c;
                end
            end
        end else if (m_st[c] == ST_WAIT) begin
            m_done = 1'b0;
            if (!m_valid[c]) begin
                m_cnt = 0; e_acc = 1; e_acc_idx = c; m_st[c] = ST_RUN; e_start = c;
            end
        end
        if (fin) begin
            m_ptr = next_entry(c);
            if (m_st[m_ptr] == ST_WAIT) begin
                m_done = 1'b0; m_cnt = 0; e_acc = 1; e_acc_idx = m_ptr;
                m_st[m_ptr] = ST_RUN; e_start = m_ptr;
            end
        end
        @(negedge clk);
        tick = 1'b0;
        tick_long = 1'b0;
        chk(done_vld == 1'b1, "R14", "done_vld after tick", int'(done_vld), 1);
        chk(cal_done == m_done, "R7 R12", "cal_done", int'(cal_done), int'(m_done));
        chk(collect == e_coll, "R3 R4", "collect", int'(collect), int'(e_coll));
        if (e_coll) chk(ent_idx == 2'(c), "R4", "collect index", int'(ent_idx), c);
        chk(post_proc == e_post, "R5", "post_proc", int'(post_proc), int'(e_post));
        if (e_post) chk(int'(post_chains) == e_chains, "R6", "chain count", int'(post_chains), e_chains);
        chk(acc_clear == e_acc, "R2", "acc_clear", int'(acc_clear), int'(e_acc));
        if (e_acc) chk(int'(acc_idx) == e_acc_idx, "R2", "acc index", int'(acc_idx), e_acc_idx);
        chk(chan_valid == m_valid, "R5", "chan_valid", int'(chan_valid), int'(m_valid));
        chk(chan_valid[2] == 1'b0, "R11", "unsupported valid bit", int'(chan_valid[2]), 0);
        chk(iq_cfg_wr == (e_start >= 0 && B_KIND[e_start] == 0), "R8", "iq_cfg_wr",
            int'(iq_cfg_wr), int'(e_start >= 0 && B_KIND[e_start] == 0));
        if (iq_cfg_wr) chk(int'(iq_log_count) == B_LOG[0], "R8", "iq_log_count", int'(iq_log_count), B_LOG[0]);
        chk(temp_local_set == (e_start >= 0 && B_KIND[e_start] == 1), "R9", "temp_local_set",
            int'(temp_local_set), int'(e_start >= 0 && B_KIND[e_start] == 1));
        chk(nf_read == lng, "R10", "nf_read", int'(nf_read), int'(lng));
        @(negedge clk);
        chk(done_vld == 1'b0, "R14", "done_vld single cycle", int'(done_vld), 0);
        chk((iq_do_cal | temp_start) == (e_start >= 0), "R8 R9", "kick strobe",
            int'(iq_do_cal | temp_start), int'(e_start >= 0));
        if (e_start >= 0) begin
            chk(int'(kick_idx) == e_start, "R8 R9", "kick index", int'(kick_idx), e_start);
            meas_busy[kick_idx] = 1'b1;
        end
        chk(nf_load == lng, "R10", "nf_load", int'(nf_load), int'(lng));
        @(negedge clk);
        chk(nf_start == lng, "R10", "nf_start", int'(nf_start), int'(lng));
    endtask

    // Clear valid bits, optionally together with a tick that must be dropped.
    task automatic do_clear(input bit [2:0] m, input bit with_tick, input bit lng);
        bit [2:0] eff;
        @(negedge clk);
        valid_clear = m;
        tick = with_tick;
        tick_long = lng;
        eff = m & 3'b011;
        m_valid = m_valid & ~m;
        for (int e = 0; e < N; e++) if (eff[e]) m_st[e] = ST_WAIT;
        for (int e = N - 1; e >= 0; e--) if (eff[e]) m_ptr = e;
        @(negedge clk);
        valid_clear = 3'b000;
        tick = 1'b0;
        tick_long = 1'b0;
        chk(chan_valid == m_valid, "R13", "valid after clear", int'(chan_valid), int'(m_valid));
        chk(done_vld == 1'b0, "R13", "tick dropped on clear", int'(done_vld), 0);
        chk(acc_clear == 1'b0 && collect == 1'b0, "R13", "no list strobe on clear",
            int'(acc_clear | collect), 0);
        chk(nf_read == lng, "R10", "nf_read with clear", int'(nf_read), int'(lng));
        repeat (3) @(negedge clk);
    endtask

    task automatic release_busy(input int pct);
        for (int e = 0; e < N; e++)
            if (meas_busy[e] && (($urandom % 100) < pct)) meas_busy[e] = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(20240611);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(chan_valid == 3'b000, "R1", "reset valid", int'(chan_valid), 0);
        chk(cal_done == 1'b0 && done_vld == 1'b0, "R1", "reset done", int'(cal_done | done_vld), 0);
        chk((acc_clear | collect | post_proc | iq_cfg_wr | iq_do_cal | temp_local_set | temp_start
             | nf_read | nf_load | nf_start) == 1'b0, "R1", "reset strobes", 1, 0);

        // Directed: start IQ, stall, sub-sample, finish with empty mask.
        do_tick(1'b0);
        do_tick(1'b0);
        meas_busy = 3'b000;
        do_tick(1'b0);
        meas_busy = 3'b000;
        rx_chain_mask = 3'b000;
        do_tick(1'b0);
        meas_busy = 3'b000;
        rx_chain_mask = 3'b111;
        do_tick(1'b1);
        do_tick(1'b0);
        do_tick(1'b1);
        // Directed: clear with a coincident long tick.
        do_clear(3'b110, 1'b1, 1'b1);
        do_tick(1'b0);

        // Random phase.
        for (int it = 0; it < 400; it++) begin
            release_busy(70);
            rx_chain_mask = 3'($urandom % 8);
            if (($urandom % 100) < 8)
                do_clear(3'($urandom % 8), 1'b0, 1'b0);
            else
                do_tick(($urandom % 4) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule